// File: doc/BRIEF.md
# Mode-Dependent Phase Slope Limiter

This block sits in a telecom digital phase-locked loop, between the phase comparator and the loop filter. It accepts a signed phase error word and forwards a limited copy. The limit is a slope: no more than a fixed amount of phase may be released per update period, so the phase the loop applies to its output moves at a bounded rate however violent the input transient. The allowed slope depends on the selected network standard. In SONET operation the slope is 885 ns per second. In SDH operation it is 53 ns every 1.326 ms.

A periodic update strobe provides the time base. On each strobe the block adds the incoming error to a signed residual of phase that has not yet been released. It then releases as much of that sum as the per-strobe budget allows and keeps the remainder for later strobes. Phase is therefore delayed but not discarded. The only exception is a residual driven past its storage range. A saturation flag reports strobes on which the limit was actually binding.

Top module: `phase_slope_limiter`

## Requirements
- R1: A synchronous active-high reset clears the residual, sets `err_out` to 0 and clears `sat`. While reset is held, `tick` and `err_in` have no effect.
- R2: Outputs change only on a clock edge where `tick` is 1. On that edge, `err_out` becomes the released value: the sum of the residual and `err_in`, clamped to the range from minus the budget to plus the budget. `err_out` and `sat` then hold until the next tick, and `err_in` values between ticks are ignored.
- R3: The budget, in LSBs, is derived from the slope parameters. With the defaults (1 LSB = 0.125 ns, tick period 1.326 ms), `mode` = 0 selects SONET with a budget of 9 LSB (885 ns/s scaled to the tick and rounded down). `mode` = 1 selects SDH with a budget of 424 LSB.
- R4: The part of the sum that is not released is stored in the residual and released on later ticks. Once the inputs return to zero, the released values add up to the sum of all inputs since reset, provided the residual never reached its limit.
- R5: `mode` is sampled only on the tick edge. A mode change between ticks takes effect on the next tick, and the residual is kept across the change.
- R6: `sat` is 1 after a tick exactly when the magnitude of the released value equals the budget and the new residual is nonzero.
- R7: The residual saturates at plus or minus (2^(RW-1) - 1) rather than wrapping. With the default RW = 24 the limit is 8388607 LSB.
- R8: When the sum equals the budget exactly, the whole sum is released, the residual becomes 0 and `sat` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Update strobe, one cycle per update period |
| mode | input | 1 | Standard select: 0 = SONET slope, 1 = SDH slope |
| err_in | input | W | Signed phase error from the comparator |
| err_out | output | W | Signed limited phase error to the loop filter |
| sat | output | 1 | Limit was binding on the last tick |

## Verification
The hardest case to reach from the ports is residual saturation. In SONET mode only 9 LSB leave per tick, so the residual has to be pumped with a full-scale positive error for more than 256 consecutive ticks before it reaches its limit. The residual itself is not visible at the ports. The bench therefore switches to SDH and feeds full-scale negative error, and the tick on which the output stops releasing the positive budget reveals the stored value, which the model predicts from the clipped residual. Random ticks with mixed modes, idle gaps that carry ignored input, and a zero-input drain that closes the phase balance cover the remaining requirements.

// File: rtl/psl_pkg.sv
package psl_pkg;

   typedef enum logic {
      PSL_SONET = 1'b0,
      PSL_SDH   = 1'b1
   } psl_mode_e;

   // Integer scaling of a slope to a per-tick budget in LSB units.
   function automatic longint psl_scale(input longint num, input longint den, input bit nearest);
      if (nearest) return (num + den / 2) / den;
      return num / den;
   endfunction

endpackage

// File: rtl/psl_budget.sv
module psl_budget #(
   parameter int W       = 16,
   parameter int B_SONET = 9,
   parameter int B_SDH   = 424
) (
   input  logic                mode,
   output logic signed [W-1:0] bud
);
   import psl_pkg::*;

   localparam logic signed [W-1:0] BS_ONET = W'(B_SONET);
   localparam logic signed [W-1:0] BS_DH   = W'(B_SDH);

   psl_mode_e md;
   assign md = psl_mode_e'(mode);

   generate
      if (B_SONET == B_SDH) begin : g_single
         assign bud = BS_ONET;
      end else begin : g_mux
         always_comb begin
            unique case (md)
               PSL_SDH: bud = BS_DH;
               default: bud = BS_ONET;
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/psl_clamp.sv
module psl_clamp #(
   parameter int W  = 16,
   parameter int RW = 24
) (
   input  logic signed [RW-1:0] res,
   input  logic signed [W-1:0]  err,
   input  logic signed [W-1:0]  bud,
   output logic signed [W-1:0]  rel,
   output logic signed [RW-1:0] rem
);
   localparam int TW = RW + 1;
   localparam logic signed [TW-1:0] RES_MAX = {2'b00, {(RW-1){1'b1}}};

   logic signed [TW-1:0] total;
   logic signed [TW-1:0] budx;
   logic signed [TW-1:0] relx;
   logic signed [TW-1:0] remw;

   always_comb begin
      total = {res[RW-1], res} + {{(TW-W){err[W-1]}}, err};
      budx  = {{(TW-W){bud[W-1]}}, bud};
      if (total > budx)       relx = budx;
      else if (total < -budx) relx = -budx;
      else                    relx = total;
      remw = total - relx;
      if (remw > RES_MAX)       remw = RES_MAX;
      else if (remw < -RES_MAX) remw = -RES_MAX;
      rel = relx[W-1:0];
      rem = remw[RW-1:0];
   end

endmodule

// File: rtl/phase_slope_limiter.sv
module phase_slope_limiter #(
   parameter int W              = 16,
   parameter int RW             = 24,
   parameter int LSB_PS         = 125,
   parameter int TICK_US        = 1326,
   parameter int SONET_PS_PER_S = 885000,
   parameter int SDH_STEP_PS    = 53000,
   parameter int SDH_WINDOW_US  = 1326,
   parameter bit ROUND_NEAREST  = 1'b0
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                tick,
   input  logic                mode,
   input  logic signed [W-1:0] err_in,
   output logic signed [W-1:0] err_out,
   output logic                sat
);
   import psl_pkg::*;

   localparam longint B_SONET_L = psl_scale(longint'(SONET_PS_PER_S) * longint'(TICK_US),
                                            64'sd1000000 * longint'(LSB_PS), ROUND_NEAREST);
   localparam longint B_SDH_L   = psl_scale(longint'(SDH_STEP_PS) * longint'(TICK_US),
                                            longint'(SDH_WINDOW_US) * longint'(LSB_PS), ROUND_NEAREST);
   localparam int B_SONET = int'(B_SONET_L);
   localparam int B_SDH   = int'(B_SDH_L);

   generate
      if (RW <= W || RW > 31) begin : g_bad_rw
         $error("phase_slope_limiter: RW must exceed W and stay below 32");
      end
      if (B_SONET_L < 1 || B_SONET_L >= (64'sd1 <<< (W-1))) begin : g_bad_sonet
         $error("phase_slope_limiter: SONET budget out of range for W");
      end
      if (B_SDH_L < 1 || B_SDH_L >= (64'sd1 <<< (W-1))) begin : g_bad_sdh
         $error("phase_slope_limiter: SDH budget out of range for W");
      end
   endgenerate

   logic signed [W-1:0]  bud;
   logic signed [W-1:0]  rel;
   logic signed [RW-1:0] rem;
   logic signed [RW-1:0] res_q;
   logic                 sat_d;

   psl_budget #(
      .W      (W),
      .B_SONET(B_SONET),
      .B_SDH  (B_SDH)
   ) i_budget (
      .mode(mode),
      .bud (bud)
   );

   psl_clamp #(
      .W (W),
      .RW(RW)
   ) i_clamp (
      .res(res_q),
      .err(err_in),
      .bud(bud),
      .rel(rel),
      .rem(rem)
   );

   assign sat_d = ((rel == bud) || (rel == -bud)) && (rem != '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         res_q   <= '0;
         err_out <= '0;
         sat     <= 1'b0;
      end else if (tick) begin
         res_q   <= rem;
         err_out <= rel;
         sat     <= sat_d;
      end
   end

endmodule

// File: rtl/psl_checker.sv
module psl_checker #(
   parameter int W       = 16,
   parameter int B_SONET = 9,
   parameter int B_SDH   = 424
) (
   input logic                clk,
   input logic                rst,
   input logic                tick,
   input logic                mode,
   input logic signed [W-1:0] err_out,
   input logic                sat
);
   logic signed [W:0] last_bud;
   logic signed [W:0] mag;

   always_ff @(posedge clk) begin
      if (rst)       last_bud <= '0;
      else if (tick) last_bud <= mode ? (W+1)'(B_SDH) : (W+1)'(B_SONET);
   end

   assign mag = err_out[W-1] ? -{err_out[W-1], err_out} : {err_out[W-1], err_out};

   p_reset_r1: assert property (@(posedge clk) rst |=> (err_out == '0 && !sat));

   p_hold_r2: assert property (@(posedge clk) disable iff (rst)
      !tick |=> ($stable(err_out) && $stable(sat)));

   p_out_bound_r3: assert property (@(posedge clk) disable iff (rst)
      mag <= last_bud);

   p_sat_full_r6: assert property (@(posedge clk) disable iff (rst)
      sat |-> (mag == last_bud));

   p_small_no_sat_r8: assert property (@(posedge clk) disable iff (rst)
      (mag < last_bud) |-> !sat);

endmodule

bind phase_slope_limiter psl_checker #(
   .W      (W),
   .B_SONET(B_SONET),
   .B_SDH  (B_SDH)
) i_psl_chk (
   .clk    (clk),
   .rst    (rst),
   .tick   (tick),
   .mode   (mode),
   .err_out(err_out),
   .sat    (sat)
);

// File: tb/test_phase_slope_limiter.sv
module test_phase_slope_limiter;
   localparam int CLK_PERIOD = 10;
   localparam int WD_CYCLES  = 150000;
   localparam longint BUD_SONET = 9;
   localparam longint BUD_SDH   = 424;
   localparam longint RES_LIM   = 8388607;

   logic               clk = 1'b0;
   logic               rst = 1'b1;
   logic               tick = 1'b0;
   logic               mode = 1'b0;
   logic signed [15:0] err_in = '0;
   logic signed [15:0] err_out;
   logic               sat;

   int checks = 0;
   int failures = 0;
   longint m_res = 0;
   longint m_out = 0;
   bit     m_sat = 1'b0;
   longint sum_in = 0;
   longint sum_out = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   phase_slope_limiter i_phase_slope_limiter (
      .clk(clk), .rst(rst), .tick(tick), .mode(mode),
      .err_in(err_in), .err_out(err_out), .sat(sat)
   );

   task automatic check_out(input string req, input longint exp_o, input bit exp_s);
      checks++;
      if (longint'(err_out) != exp_o || sat != exp_s) begin
         failures++;
         $display("FAIL %s: err_out=%0d sat=%0d expected err_out=%0d sat=%0d",
                  req, err_out, sat, exp_o, exp_s);
      end
   endtask

   // Expected behaviour of one tick, from the requirements.
   task automatic model_tick(input bit md, input longint e);
      longint b, tot, rel, rem;
      b   = md ? BUD_SDH : BUD_SONET;
      tot = m_res + e;
      if (tot > b)       rel = b;
      else if (tot < -b) rel = -b;
      else               rel = tot;
      rem = tot - rel;
      if (rem > RES_LIM)  rem = RES_LIM;
      if (rem < -RES_LIM) rem = -RES_LIM;
      m_sat = ((rel == b) || (rel == -b)) && (rem != 0);
      m_res = rem;
      m_out = rel;
      sum_in  += e;
      sum_out += rel;
   endtask

   task automatic do_tick(input string req, input bit md, input int e);
      mode = md;
      err_in = 16'(e);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      model_tick(md, longint'(e));
      check_out(req, m_out, m_sat);
   endtask

   // Idle cycles carrying noise on err_in and mode (R2: ignored between ticks).
   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         err_in = 16'($urandom_range(0, 65535));
         mode = 1'($urandom_range(0, 1));
         @(negedge clk);
         check_out("R2 hold between ticks", m_out, m_sat);
      end
   endtask

   task automatic do_reset();
      rst = 1'b1;
      tick = 1'b1;
      err_in = 16'sd500;
      repeat (2) @(negedge clk);
      check_out("R1 reset state", 0, 1'b0);
      rst = 1'b0;
      tick = 1'b0;
      m_res = 0; m_out = 0; m_sat = 1'b0;
      sum_in = 0; sum_out = 0;
   endtask

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      @(negedge clk);
      do_reset();

      // Directed corner cases
      do_tick("R2 small pass SDH", 1'b1, 100);
      do_tick("R8 exact SDH budget", 1'b1, 424);
      do_tick("R8 exact SONET budget", 1'b0, 9);
      do_tick("R3 R6 SONET clamp", 1'b0, 10);
      do_tick("R4 residual released", 1'b0, 0);
      do_tick("R3 R6 SONET negative clamp", 1'b0, -30);
      idle(3);
      do_tick("R5 mode change keeps residual", 1'b1, 0);
      do_tick("R3 SDH positive clamp", 1'b1, 1000);
      do_tick("R5 SONET after SDH residual", 1'b0, 0);
      idle(2);
      do_reset();
      do_tick("R1 residual cleared by reset", 1'b1, 0);
      do_tick("R3 SDH negative clamp", 1'b1, -5000);

      // Random ticks with mixed modes and idle gaps
      for (int k = 0; k < 1500; k++) begin
         int e;
         if ($urandom_range(0, 7) == 0) e = int'($urandom_range(0, 65535)) - 32768;
         else                           e = int'($urandom_range(0, 200)) - 100;
         do_tick("R2 R3 R6 random tick", 1'($urandom_range(0, 1)), e);
         idle(int'($urandom_range(0, 3)));
      end

      // Drain with zero input and check the phase balance
      for (int k = 0; k < 20000 && m_res != 0; k++) do_tick("R4 drain", 1'b1, 0);
      do_tick("R4 drained output zero", 1'b1, 0);
      checks++;
      if (sum_out != sum_in) begin
         failures++;
         $display("FAIL R4 phase balance: released=%0d expected=%0d", sum_out, sum_in);
      end

      // Residual saturation: pump in SONET mode, then unwind in SDH mode
      do_reset();
      for (int k = 0; k < 300; k++) do_tick("R7 pump residual", 1'b0, 32767);
      for (int k = 0; k < 270; k++) do_tick("R7 unwind saturated residual", 1'b1, -32768);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule